// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue and Interrupts

This block recovers characters from an asynchronous serial line and places them in a sixteen-entry receive queue. It follows the line with a 16x oversampling tick supplied from outside. A falling edge starts a character. Data bits arrive least significant first, followed by an optional parity bit and then one or two stop bits. For each completed character the block decides whether to keep it, and it records what went wrong in sticky status flags.

Five flags describe the receive path: queue-threshold reached, data ready, receive error, break and overrun. Three level-sensitive interrupt lines are derived from these flags. Two enable inputs gate the interrupt lines, and the gating overlaps between lines. Software-side logic reads the queue through a pop strobe with show-ahead data. It clears each flag with a one-cycle strobe. Line configuration is static while the line is idle: parity mode, 7 or 8 data bits, one or two stop bits, and the queue threshold.

Top module: `async_rx_fifo`

## Requirements
- R1: A low level seen on a tick while idle is confirmed on the 8th tick that follows. If the line is high again at that point, the receiver returns to idle, and nothing is stored or flagged.
- R2: Data bits are assembled least significant bit first. `cfg_len7`=1 selects 7 data bits, with bit 7 read as 0, and 0 selects 8. Characters leave the queue in arrival order on `rd_data`, which shows the oldest entry before `rd_pop`.
- R3: `cfg_parity` encodes 0 and 3 as no parity bit, 1 as even and 2 as odd. A parity mismatch sets `flag_err`, and the character is still stored.
- R4: Only the first stop bit is checked. If it is 0, `flag_err` is set and a non-break character is still stored. With `cfg_two_stop`=1, a 0 in the second stop position causes no error.
- R5: A completed non-break character is written only when the queue holds fewer than 16 entries and both `flag_ovr` and `flag_brk` are clear. `fifo_count` never exceeds 16.
- R6: A non-break character that completes while the queue holds 16 entries sets `flag_ovr` and is discarded.
- R7: A break is a 0 first stop bit with all data bits 0 and, when parity is enabled, a parity bit of 0. It sets `flag_brk` and `flag_err` and stores nothing. After any 0 first stop bit, the receiver waits for the line to go high before it looks for a new start.
- R8: Each stored character sets `flag_ready`. A store that brings the count to at least the threshold sets `flag_full`. The threshold is selected by `cfg_trig` as 0→1, 1→4, 2→8 and 3→14.
- R9: `irq_rx` is high exactly when `en_rx_irq` is 1 and `flag_full` or `flag_ready` is 1.
- R10: `irq_err` is high exactly when `en_rx_irq` or `en_err_irq` is 1 and `flag_err` is 1.
- R11: `irq_bo` is high exactly when `en_rx_irq` or `en_err_irq` is 1 and `flag_brk` or `flag_ovr` is 1.
- R12: Reset empties the queue and clears all flags. Each clear strobe clears its own flag. A pop on an empty queue leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| cfg_len7 | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_trig | input | 2 | Threshold select: 1, 4, 8, 14 |
| en_rx_irq | input | 1 | Receive interrupt enable |
| en_err_irq | input | 1 | Error interrupt enable |
| rd_pop | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Oldest queue entry (show-ahead) |
| fifo_count | output | 5 | Entries held |
| clr_full | input | 1 | Clear threshold flag |
| clr_ready | input | 1 | Clear data-ready flag |
| clr_err | input | 1 | Clear error flag |
| clr_brk | input | 1 | Clear break flag |
| clr_ovr | input | 1 | Clear overrun flag |
| flag_full | output | 1 | Threshold reached |
| flag_ready | output | 1 | Character stored |
| flag_err | output | 1 | Parity or stop-bit error |
| flag_brk | output | 1 | Break received |
| flag_ovr | output | 1 | Overrun |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_bo | output | 1 | Break/overrun interrupt |

## Verification
Directed frames cover the following cases:
- A short low pulse, which separates start confirmation from edge-only triggering.
- A known byte in 8-bit mode and a masked byte in 7-bit mode, which expose the bit order and the length handling.
- Frames with a corrupted parity bit under even and odd modes, and frames with a zero stop bit, which show that errors are flagged without blocking storage.
- An all-zero frame with a held-low line, which separates a break from a plain stop-bit error.

Filling the queue to each threshold and then past 16 entries separates the threshold flag from overrun, and shows that a set overrun or break flag blocks later stores. Seeded random frames then mix data, parity mode, length, stop count, enables and clears, which catches interactions the directed cases miss.

// File: rtl/arx_pkg.sv
package arx_pkg;

   typedef enum logic [1:0] {
      PAR_OFF    = 2'd0,
      PAR_EVEN   = 2'd1,
      PAR_ODD    = 2'd2,
      PAR_OFF_B  = 2'd3
   } par_mode_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_STOP2,
      ST_MARKWAIT
   } rx_state_t;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
      logic       brk;
   } rx_char_t;

   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/arx_bit_engine.sv
module arx_bit_engine
   import arx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx_in,
   input  logic [1:0] cfg_parity,
   input  logic       cfg_len7,
   input  logic       cfg_two_stop,
   output logic       done,
   output rx_char_t   char_o
);

   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_single
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= rx_in;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
         end
      end
   endgenerate

   assign rx_s = sync_q[SYNC_STAGES-1];

   par_mode_t pm;
   logic      par_en, par_odd;
   logic [2:0] last_bit;
   assign pm       = par_mode_t'(cfg_parity);
   assign par_en   = (pm == PAR_EVEN) || (pm == PAR_ODD);
   assign par_odd  = (pm == PAR_ODD);
   assign last_bit = cfg_len7 ? 3'd6 : 3'd7;

   rx_state_t    state;
   logic [CW-1:0] cnt;
   logic [2:0]   bit_idx;
   logic [7:0]   shreg;
   logic         par_bit;
   logic         stop_bad, is_break;

   assign stop_bad = !rx_s;
   assign is_break = stop_bad && (shreg == 8'h00) && !par_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         par_bit <= 1'b0;
         done    <= 1'b0;
         char_o  <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (tick && !rx_s) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
            end
            ST_START: begin
               if (tick) begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     if (rx_s) begin
                        state <= ST_IDLE;
                     end else begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_bit <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (cnt == LAST) begin
                     cnt            <= '0;
                     shreg[bit_idx] <= rx_s;
                     if (bit_idx == last_bit) state <= par_en ? ST_PAR : ST_STOP;
                     else                     bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               if (tick) begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     par_bit <= rx_s;
                     state   <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_STOP: begin
               if (tick) begin
                  if (cnt == LAST) begin
                     cnt         <= '0;
                     done        <= 1'b1;
                     char_o.data <= shreg;
                     char_o.perr <= par_en && (par_bit != ((^shreg) ^ par_odd));
                     char_o.ferr <= stop_bad;
                     char_o.brk  <= is_break;
                     if (stop_bad)          state <= ST_MARKWAIT;
                     else if (cfg_two_stop) state <= ST_STOP2;
                     else                   state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_STOP2: begin
               if (tick) begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     state <= ST_MARKWAIT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_MARKWAIT: begin
               if (rx_s) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/arx_fifo.sv
module arx_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CNTW-1:0]  count
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
   localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             wr_ok, rd_ok;

   assign wr_ok = push && (count != CNT_FULL);
   assign rd_ok = pop && (count != '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
         count <= count + CNTW'(wr_ok) - CNTW'(rd_ok);
      end
   end

endmodule

// File: rtl/arx_flags.sv
module arx_flags
   import arx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            done,
   input  logic            perr,
   input  logic            ferr,
   input  logic            brk_det,
   input  logic [CNTW-1:0] count,
   input  logic [1:0]      trig_sel,
   input  logic            clr_full,
   input  logic            clr_ready,
   input  logic            clr_err,
   input  logic            clr_brk,
   input  logic            clr_ovr,
   input  logic            en_rx_irq,
   input  logic            en_err_irq,
   output logic            push,
   output logic            flag_full,
   output logic            flag_ready,
   output logic            flag_err,
   output logic            flag_brk,
   output logic            flag_ovr,
   output logic            irq_rx,
   output logic            irq_err,
   output logic            irq_bo
);

   localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

   logic          room, set_ovr, set_full, set_err, set_brk, err_gate;
   logic [CNTW:0] cnt_after;

   assign room      = (count != CNT_FULL);
   assign push      = done && !brk_det && room && !flag_ovr && !flag_brk;
   assign set_ovr   = done && !brk_det && !room;
   assign set_err   = done && (perr || ferr);
   assign set_brk   = done && brk_det;
   assign cnt_after = {1'b0, count} + 1'b1;
   assign set_full  = push && (cnt_after >= (CNTW+1)'(trig_level(trig_sel)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_full  <= 1'b0;
         flag_ready <= 1'b0;
         flag_err   <= 1'b0;
         flag_brk   <= 1'b0;
         flag_ovr   <= 1'b0;
      end else begin
         flag_full  <= (flag_full  && !clr_full)  || set_full;
         flag_ready <= (flag_ready && !clr_ready) || push;
         flag_err   <= (flag_err   && !clr_err)   || set_err;
         flag_brk   <= (flag_brk   && !clr_brk)   || set_brk;
         flag_ovr   <= (flag_ovr   && !clr_ovr)   || set_ovr;
      end
   end

   assign err_gate = en_rx_irq || en_err_irq;
   assign irq_rx   = en_rx_irq && (flag_full || flag_ready);
   assign irq_err  = err_gate && flag_err;
   assign irq_bo   = err_gate && (flag_brk || flag_ovr);

endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
   import arx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNTW       = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick16,
   input  logic            rx_line,
   input  logic [1:0]      cfg_parity,
   input  logic            cfg_len7,
   input  logic            cfg_two_stop,
   input  logic [1:0]      cfg_trig,
   input  logic            en_rx_irq,
   input  logic            en_err_irq,
   input  logic            rd_pop,
   output logic [7:0]      rd_data,
   output logic [CNTW-1:0] fifo_count,
   input  logic            clr_full,
   input  logic            clr_ready,
   input  logic            clr_err,
   input  logic            clr_brk,
   input  logic            clr_ovr,
   output logic            flag_full,
   output logic            flag_ready,
   output logic            flag_err,
   output logic            flag_brk,
   output logic            flag_ovr,
   output logic            irq_rx,
   output logic            irq_err,
   output logic            irq_bo
);

   if (DEPTH < 14) begin : g_bad_depth
      $error("DEPTH must hold the largest threshold (14)");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic     done, push;
   rx_char_t rx_char;

   arx_bit_engine #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick16),
      .rx_in       (rx_line),
      .cfg_parity  (cfg_parity),
      .cfg_len7    (cfg_len7),
      .cfg_two_stop(cfg_two_stop),
      .done        (done),
      .char_o      (rx_char)
   );

   arx_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .din  (rx_char.data),
      .pop  (rd_pop),
      .dout (rd_data),
      .count(fifo_count)
   );

   arx_flags #(.DEPTH(DEPTH)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .perr      (rx_char.perr),
      .ferr      (rx_char.ferr),
      .brk_det   (rx_char.brk),
      .count     (fifo_count),
      .trig_sel  (cfg_trig),
      .clr_full  (clr_full),
      .clr_ready (clr_ready),
      .clr_err   (clr_err),
      .clr_brk   (clr_brk),
      .clr_ovr   (clr_ovr),
      .en_rx_irq (en_rx_irq),
      .en_err_irq(en_err_irq),
      .push      (push),
      .flag_full (flag_full),
      .flag_ready(flag_ready),
      .flag_err  (flag_err),
      .flag_brk  (flag_brk),
      .flag_ovr  (flag_ovr),
      .irq_rx    (irq_rx),
      .irq_err   (irq_err),
      .irq_bo    (irq_bo)
   );

endmodule

// File: rtl/arx_checker.sv
module arx_checker #(
   parameter int DEPTH = 16,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [CNTW-1:0] fifo_count,
   input logic            en_rx_irq,
   input logic            en_err_irq,
   input logic            flag_full,
   input logic            flag_ready,
   input logic            flag_err,
   input logic            flag_brk,
   input logic            flag_ovr,
   input logic            irq_rx,
   input logic            irq_err,
   input logic            irq_bo
);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNTW'(DEPTH)); // R5
   AST_BLOCKED_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ovr || flag_brk) |=> fifo_count <= $past(fifo_count)); // R5
   AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_ovr) |-> $past(fifo_count) == CNTW'(DEPTH)); // R6
   AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_rx_irq |-> !irq_rx); // R9
   AST_RX_IRQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rx_irq && (flag_full || flag_ready)) |-> irq_rx); // R9
   AST_ERR_IRQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_rx_irq || en_err_irq) && flag_err) |-> irq_err); // R10
   AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_rx_irq || en_err_irq) |-> !irq_err); // R10
   AST_BO_IRQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_rx_irq || en_err_irq) && (flag_brk || flag_ovr)) |-> irq_bo); // R11
   AST_BO_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_brk || flag_ovr) |-> !irq_bo); // R11
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count == '0 |=> fifo_count <= CNTW'(1)); // R12

endmodule

bind async_rx_fifo arx_checker #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_count(fifo_count),
   .en_rx_irq (en_rx_irq),
   .en_err_irq(en_err_irq),
   .flag_full (flag_full),
   .flag_ready(flag_ready),
   .flag_err  (flag_err),
   .flag_brk  (flag_brk),
   .flag_ovr  (flag_ovr),
   .irq_rx    (irq_rx),
   .irq_err   (irq_err),
   .irq_bo    (irq_bo)
);

// File: tb/async_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module async_rx_fifo_tb_top;

   localparam int DEPTH = 16;
   localparam int CNTW  = $clog2(DEPTH + 1);
   localparam int BIT   = 32;

   logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx_line = 1'b1;
   logic [1:0] cfg_parity = 2'd0, cfg_trig = 2'd3;
   logic cfg_len7 = 1'b0, cfg_two_stop = 1'b0;
   logic en_rx_irq = 1'b1, en_err_irq = 1'b0, rd_pop = 1'b0;
   logic clr_full = 1'b0, clr_ready = 1'b0, clr_err = 1'b0, clr_brk = 1'b0, clr_ovr = 1'b0;
   logic [7:0] rd_data;
   logic [CNTW-1:0] fifo_count;
   logic flag_full, flag_ready, flag_err, flag_brk, flag_ovr, irq_rx, irq_err, irq_bo;

   async_rx_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
      .cfg_parity(cfg_parity), .cfg_len7(cfg_len7), .cfg_two_stop(cfg_two_stop),
      .cfg_trig(cfg_trig), .en_rx_irq(en_rx_irq), .en_err_irq(en_err_irq),
      .rd_pop(rd_pop), .rd_data(rd_data), .fifo_count(fifo_count),
      .clr_full(clr_full), .clr_ready(clr_ready), .clr_err(clr_err),
      .clr_brk(clr_brk), .clr_ovr(clr_ovr),
      .flag_full(flag_full), .flag_ready(flag_ready), .flag_err(flag_err),
      .flag_brk(flag_brk), .flag_ovr(flag_ovr),
      .irq_rx(irq_rx), .irq_err(irq_err), .irq_bo(irq_bo)
   );

   always #2.5 clk = ~clk;

   int n_checks = 0, n_errors = 0;
   bit finished = 1'b0;
   logic [7:0] q[$];
   bit m_full, m_ready, m_err, m_brk, m_ovr;

   initial begin
      forever begin
         @(negedge clk); tick16 = 1'b1;
         @(negedge clk); tick16 = 1'b0;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int trig_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic bit par_on();
      return (cfg_parity == 2'd1) || (cfg_parity == 2'd2);
   endfunction

   function automatic logic [7:0] mask_of(input logic [7:0] d);
      return cfg_len7 ? (d & 8'h7f) : d;
   endfunction

   function automatic bit good_par(input logic [7:0] d);
      return (^mask_of(d)) ^ (cfg_parity == 2'd2);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_state();
      bit gate_any;
      gate_any = en_rx_irq || en_err_irq;
      chk("R5",  "fifo_count", int'(fifo_count), q.size());
      chk("R8",  "flag_full",  int'(flag_full),  int'(m_full));
      chk("R8",  "flag_ready", int'(flag_ready), int'(m_ready));
      chk("R3",  "flag_err",   int'(flag_err),   int'(m_err));
      chk("R7",  "flag_brk",   int'(flag_brk),   int'(m_brk));
      chk("R6",  "flag_ovr",   int'(flag_ovr),   int'(m_ovr));
      chk("R9",  "irq_rx",     int'(irq_rx),     int'(en_rx_irq && (m_full || m_ready)));
      chk("R10", "irq_err",    int'(irq_err),    int'(gate_any && m_err));
      chk("R11", "irq_bo",     int'(irq_bo),     int'(gate_any && (m_brk || m_ovr)));
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                             input bit stop2_low, input int hold_low);
      logic [7:0] dm;
      bit pbit, brk;
      int nb;
      dm   = mask_of(d);
      pbit = good_par(d) ^ bad_par;
      nb   = cfg_len7 ? 7 : 8;
      rx_line = 1'b0; wait_clk(BIT);
      for (int i = 0; i < nb; i++) begin rx_line = dm[i]; wait_clk(BIT); end
      if (par_on()) begin rx_line = pbit; wait_clk(BIT); end
      rx_line = !bad_stop; wait_clk(BIT);
      if (cfg_two_stop) begin rx_line = bad_stop ? 1'b0 : !stop2_low; wait_clk(BIT); end
      if (bad_stop) wait_clk(hold_low * BIT);
      rx_line = 1'b1; wait_clk(2 * BIT);
      brk = bad_stop && (dm == 8'h00) && (!par_on() || !pbit);
      if (brk) begin
         m_brk = 1'b1; m_err = 1'b1;
      end else begin
         if (bad_stop || (par_on() && bad_par)) m_err = 1'b1;
         if (q.size() == DEPTH) m_ovr = 1'b1;
         else if (!m_ovr && !m_brk) begin
            q.push_back(dm);
            m_ready = 1'b1;
            if (q.size() >= trig_of(cfg_trig)) m_full = 1'b1;
         end
      end
   endtask

   task automatic pop_check(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         if (q.size() != 0) begin
            chk(req, "rd_data", int'(rd_data), int'(q[0]));
            void'(q.pop_front());
         end
         rd_pop = 1'b1; wait_clk(1); rd_pop = 1'b0;
      end
   endtask

   task automatic clear(input bit f, input bit r, input bit e, input bit b, input bit o);
      clr_full = f; clr_ready = r; clr_err = e; clr_brk = b; clr_ovr = o;
      wait_clk(1);
      clr_full = 0; clr_ready = 0; clr_err = 0; clr_brk = 0; clr_ovr = 0;
      if (f) m_full = 0;
      if (r) m_ready = 0;
      if (e) m_err = 0;
      if (b) m_brk = 0;
      if (o) m_ovr = 0;
   endtask

   initial begin
      int lvl;
      void'($urandom(32'h5eed_1234));
      m_full = 0; m_ready = 0; m_err = 0; m_brk = 0; m_ovr = 0;
      wait_clk(5); rst_n = 1'b1; wait_clk(4);

      // R12: reset state
      chk("R12", "count after reset", int'(fifo_count), 0);
      check_state();

      // R2: 8-bit frame, LSB first
      send_frame(8'hA5, 0, 0, 0, 0);
      check_state();
      pop_check(1, "R2");

      // R1: short low pulse is rejected
      rx_line = 1'b0; wait_clk(6); rx_line = 1'b1; wait_clk(3 * BIT);
      chk("R1", "glitch count", int'(fifo_count), 0);
      check_state();

      // R3: even and odd parity, 7-bit length
      cfg_len7 = 1; cfg_parity = 2'd1; en_rx_irq = 0; en_err_irq = 1;
      send_frame(8'hDA, 0, 0, 0, 0);
      chk("R3", "good even parity flag_err", int'(flag_err), 0);
      send_frame(8'h33, 1, 0, 0, 0);
      chk("R3", "bad even parity flag_err", int'(flag_err), 1);
      check_state();
      pop_check(2, "R2");
      clear(1, 1, 1, 0, 0);
      cfg_parity = 2'd2; cfg_len7 = 0;
      send_frame(8'h81, 0, 0, 0, 0);
      chk("R3", "good odd parity flag_err", int'(flag_err), 0);
      send_frame(8'h7E, 1, 0, 0, 0);
      check_state();
      en_err_irq = 0;
      wait_clk(1);
      chk("R10", "irq_err gated off", int'(irq_err), 0);
      pop_check(2, "R3");
      clear(1, 1, 1, 0, 0);
      chk("R12", "flag_err after clear", int'(flag_err), 0);

      // R4: two stop bits, second ignored; bad first stop
      cfg_parity = 2'd0; cfg_two_stop = 1; en_rx_irq = 1;
      send_frame(8'h3C, 0, 0, 1, 0);
      chk("R4", "second stop low flag_err", int'(flag_err), 0);
      send_frame(8'h42, 0, 1, 0, 1);
      chk("R4", "bad first stop flag_err", int'(flag_err), 1);
      check_state();
      pop_check(2, "R4");
      clear(1, 1, 1, 0, 0);
      cfg_two_stop = 0;

      // R7: break, then a frame while break is set (R5)
      en_rx_irq = 0; en_err_irq = 1;
      send_frame(8'h00, 0, 1, 0, 4);
      chk("R7", "break flag", int'(flag_brk), 1);
      chk("R7", "break not stored", int'(fifo_count), 0);
      chk("R11", "irq_bo on break", int'(irq_bo), 1);
      send_frame(8'h55, 0, 0, 0, 0);
      chk("R5", "stored while break set", int'(fifo_count), 0);
      check_state();
      clear(1, 1, 1, 1, 0);
      en_rx_irq = 1;
      send_frame(8'h55, 0, 0, 0, 0);
      check_state();
      pop_check(1, "R5");

      // R12: pop on empty
      pop_check(1, "R12");
      chk("R12", "pop on empty count", int'(fifo_count), 0);

      // R8: trigger levels
      for (int s = 0; s < 4; s++) begin
         cfg_trig = 2'(s);
         lvl = trig_of(cfg_trig);
         pop_check(q.size(), "R2");
         clear(1, 1, 1, 1, 1);
         for (int k = 1; k <= lvl; k++) begin
            send_frame(8'($urandom), 0, 0, 0, 0);
            chk("R8", "flag_full at level", int'(flag_full), int'(k >= lvl));
         end
         check_state();
      end

      // R6: overrun at 16 entries
      send_frame(8'h11, 0, 0, 0, 0);
      send_frame(8'h22, 0, 0, 0, 0);
      chk("R5", "queue full count", int'(fifo_count), 16);
      send_frame(8'h33, 0, 0, 0, 0);
      chk("R6", "overrun flag", int'(flag_ovr), 1);
      chk("R6", "overrun discarded", int'(fifo_count), 16);
      pop_check(1, "R2");
      send_frame(8'h44, 0, 0, 0, 0);
      chk("R5", "blocked by overrun", int'(fifo_count), 15);
      clear(0, 0, 0, 0, 1);
      send_frame(8'h66, 0, 0, 0, 0);
      chk("R5", "stored after clear", int'(fifo_count), 16);
      check_state();
      pop_check(q.size(), "R2");
      clear(1, 1, 1, 1, 1);

      // random mix
      for (int n = 0; n < 40; n++) begin
         cfg_parity   = 2'($urandom % 4);
         cfg_len7     = 1'($urandom % 2);
         cfg_two_stop = 1'($urandom % 2);
         cfg_trig     = 2'($urandom % 4);
         en_rx_irq    = 1'($urandom % 2);
         en_err_irq   = 1'($urandom % 2);
         send_frame(8'($urandom), ($urandom % 8) == 0, ($urandom % 10) == 0,
                    1'($urandom % 2), 1);
         check_state();
         if (q.size() > 12) pop_check(6, "R2");
         if (($urandom % 4) == 0) begin
            clear(1, 1, 1, 1, 1);
            check_state();
         end
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule